// File: doc/BRIEF.md
# Flash Query-Mode Command Interpreter

This block handles the command side of a multi-bank flash device that offers a standard identification query. It watches 16-bit bus writes. When it sees the query entry command at the correct word offset, it switches one bank into query mode. While that bank is in query mode, reads to it are answered from a fixed identification table instead of the storage array. Reads to every other bank still go to the array through a simple request path.

A reset command written to the query bank returns the whole device to array-read mode. While query mode is active, writes to any other bank are refused. Reads to the query bank at an offset that is not in the table return a fixed invalid value.

The bus address splits into two fields:
- the bank number, held in the upper bits;
- a 16-bit word offset within the bank, held in the lower bits.

Read data is registered and appears one cycle after the read strobe.

Top module: `flashq_cmd_top`

## Requirements
- R1: In array-read mode, a write whose data low byte is 0x98 and whose offset low 12 bits are 0x555 enters query mode. On the next cycle `qry_active_o` is 1 and `qry_bank_o` holds the bank field, which is address bits 19:16.
- R2: In query mode, reads in the query bank at offsets 0x10, 0x11 and 0x12 return 0x0051, 0x0052 and 0x0059 respectively.
- R3: In query mode, reads in the query bank at offsets 0x13 to 0x26 return the following values, in offset order: 0002, 0000, 0040, 0000, 0000, 0000, 0000, 0000, 0017, 0019, 0000, 0000, 0006, 0009, 000A, 0000, 0004, 0004, 0003, 0000 (hex).
- R4: In query mode, reads in the query bank at any offset outside 0x10 to 0x26 return 0x0000.
- R5: Any read that is not to the query bank while query mode is active raises `arr_rd_o` in the same cycle, with `arr_addr_o` equal to the bus address, and returns `arr_rdata_i` as the read data. This covers all reads in array-read mode and reads to other banks in query mode. Reads to the query bank keep `arr_rd_o` low.
- R6: While query mode is active, writes to any other bank change neither the mode nor the active bank. This holds even when the write carries 0xF0, or 0x98 at offset 0x555.
- R7: While query mode is active, a write to the query bank with data low byte 0xF0 returns the device to array-read mode on the next cycle, with `qry_bank_o` set to 0.
- R8: While query mode is active, writes to the query bank with any other data leave the mode and bank unchanged. This includes a repeated 0x98 at offset 0x555.
- R9: A synchronous active-high reset clears the mode to array-read, clears the active bank to 0, and clears `rvalid_o` and `rdata_o`.
- R10: `rvalid_o` is high exactly one cycle after each cycle in which `rd_i` is high. Back-to-back reads give back-to-back results in order.
- R11: In array-read mode, a 0x98 write whose offset low 12 bits are not 0x555 has no effect. Offset bits 15:12 are not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 20 | Bank (bits 19:16) and word offset (bits 15:0) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_i` |
| arr_rd_o | output | 1 | Read request to the array path |
| arr_addr_o | output | 20 | Array read address |
| arr_rdata_i | input | 16 | Array data, sampled in the request cycle |
| qry_active_o | output | 1 | Query mode active |
| qry_bank_o | output | 4 | Bank that owns query mode |

## Verification
A mode change from a write shows on `qry_active_o` and `qry_bank_o` at the first clock edge after the write strobe. The bench therefore checks the mode flags at the falling edge that follows that edge.

Read data comes one cycle after the strobe. The read driver pushes each expected word into a queue in the cycle it raises `rd_i`, and a monitor pops the queue whenever it sees `rvalid_o` at a falling edge. Any `rvalid_o` with an empty queue, or a queue left non-empty at the end, is counted as a failure.

`arr_rd_o` is combinational, so the bench checks it one time unit after the read is driven, inside the same cycle.

// File: rtl/flashq_pkg.sv
package flashq_pkg;

    localparam int BANK_W   = 4;
    localparam int OFS_W    = 16;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = BANK_W + OFS_W;
    localparam int MATCH_W  = 12;
    localparam int TAB_LO   = 16;
    localparam int TAB_HI   = 38;
    localparam int TAB_N    = TAB_HI - TAB_LO + 1;

    localparam logic [MATCH_W-1:0] ENTRY_OFS   = 12'h555;
    localparam logic [7:0]         OP_ENTER    = 8'h98;
    localparam logic [7:0]         OP_LEAVE    = 8'hF0;
    localparam logic [DATA_W-1:0]  BAD_WORD    = '0;

    typedef enum logic {
        MODE_ARRAY = 1'b0,
        MODE_QUERY = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e              mode;
        logic [BANK_W-1:0]  bank;
    } mode_s;

    typedef struct packed {
        logic               hit;
        logic [DATA_W-1:0]  word;
    } tab_s;

    function automatic tab_s id_lookup(input logic [OFS_W-1:0] ofs);
        tab_s r;
        r.hit  = (ofs >= OFS_W'(TAB_LO)) && (ofs <= OFS_W'(TAB_HI));
        r.word = BAD_WORD;
        case (ofs)
            16'h0010: r.word = 16'h0051;
            16'h0011: r.word = 16'h0052;
            16'h0012: r.word = 16'h0059;
            16'h0013: r.word = 16'h0002;
            16'h0015: r.word = 16'h0040;
            16'h001B: r.word = 16'h0017;
            16'h001C: r.word = 16'h0019;
            16'h001F: r.word = 16'h0006;
            16'h0020: r.word = 16'h0009;
            16'h0021: r.word = 16'h000A;
            16'h0023: r.word = 16'h0004;
            16'h0024: r.word = 16'h0004;
            16'h0025: r.word = 16'h0003;
            default:  r.word = BAD_WORD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flashq_mode_ctl.sv
module flashq_mode_ctl
    import flashq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_i,
    input  logic [BANK_W-1:0]  bank_i,
    input  logic [OFS_W-1:0]   ofs_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output mode_s              state_o
);

    mode_s state_q;
    mode_s state_d;
    logic  is_entry;
    logic  is_leave;
    logic  own_bank;

    assign is_entry = (ofs_i[MATCH_W-1:0] == ENTRY_OFS) && (wdata_i[7:0] == OP_ENTER);
    assign is_leave = (wdata_i[7:0] == OP_LEAVE);
    assign own_bank = (bank_i == state_q.bank);

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            unique case (state_q.mode)
                MODE_ARRAY: if (is_entry) begin
                    state_d.mode = MODE_QUERY;
                    state_d.bank = bank_i;
                end
                MODE_QUERY: if (own_bank && is_leave) begin
                    state_d.mode = MODE_ARRAY;
                    state_d.bank = '0;
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q.mode <= MODE_ARRAY;
            state_q.bank <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R1
    a_r1_entry: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && state_q.mode == MODE_ARRAY && ofs_i[MATCH_W-1:0] == 12'h555 && wdata_i[7:0] == 8'h98)
        |=> (state_q.mode == MODE_QUERY && state_q.bank == $past(bank_i)));

    // R6
    a_r6_foreign_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && state_q.mode == MODE_QUERY && bank_i != state_q.bank)
        |=> (state_q.mode == MODE_QUERY && $stable(state_q.bank)));

    // R7
    a_r7_leave: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && state_q.mode == MODE_QUERY && bank_i == state_q.bank && wdata_i[7:0] == 8'hF0)
        |=> (state_q.mode == MODE_ARRAY && state_q.bank == '0));

    // R8
    a_r8_ignore: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && state_q.mode == MODE_QUERY && wdata_i[7:0] != 8'hF0)
        |=> (state_q.mode == MODE_QUERY && $stable(state_q.bank)));

endmodule

// File: rtl/flashq_rd_path.sv
module flashq_rd_path
    import flashq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               rd_i,
    input  logic [BANK_W-1:0]  bank_i,
    input  logic [OFS_W-1:0]   ofs_i,
    input  mode_s              state_i,
    input  logic [DATA_W-1:0]  arr_rdata_i,
    output logic               arr_rd_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               rvalid_o
);

    logic              q_hit;
    tab_s              tab;
    logic [DATA_W-1:0] rdata_d;

    assign q_hit    = (state_i.mode == MODE_QUERY) && (bank_i == state_i.bank);
    assign arr_rd_o = rd_i && !q_hit;
    assign tab      = id_lookup(ofs_i);

    always_comb begin
        if (q_hit) rdata_d = tab.hit ? tab.word : BAD_WORD;
        else       rdata_d = arr_rdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_i;
            if (rd_i) rdata_o <= rdata_d;
        end
    end

    // R10
    a_r10_latency: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_i |=> rvalid_o);
    a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_i |=> !rvalid_o);

    // R4
    a_r4_invalid: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && state_i.mode == MODE_QUERY && bank_i == state_i.bank
         && (ofs_i < 16'h0010 || ofs_i > 16'h0026))
        |=> (rdata_o == 16'h0000));

    // R5
    a_r5_array_data: assert property (@(posedge clk_i) disable iff (rst_i)
        arr_rd_o |=> (rdata_o == $past(arr_rdata_i)));

endmodule

// File: rtl/flashq_cmd_top.sv
module flashq_cmd_top
    import flashq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               rvalid_o,
    output logic               arr_rd_o,
    output logic [ADDR_W-1:0]  arr_addr_o,
    input  logic [DATA_W-1:0]  arr_rdata_i,
    output logic               qry_active_o,
    output logic [BANK_W-1:0]  qry_bank_o
);

    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  ofs;
    mode_s             state;

    assign bank = addr_i[ADDR_W-1:OFS_W];
    assign ofs  = addr_i[OFS_W-1:0];

    flashq_mode_ctl u_mode (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (wr_i),
        .bank_i  (bank),
        .ofs_i   (ofs),
        .wdata_i (wdata_i),
        .state_o (state)
    );

    flashq_rd_path u_rd (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .rd_i        (rd_i),
        .bank_i      (bank),
        .ofs_i       (ofs),
        .state_i     (state),
        .arr_rdata_i (arr_rdata_i),
        .arr_rd_o    (arr_rd_o),
        .rdata_o     (rdata_o),
        .rvalid_o    (rvalid_o)
    );

    assign arr_addr_o   = addr_i;
    assign qry_active_o = (state.mode == MODE_QUERY);
    assign qry_bank_o   = state.bank;

    // R5
    a_r5_no_array_in_query_bank: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && qry_active_o && addr_i[ADDR_W-1:OFS_W] == qry_bank_o) |-> !arr_rd_o);

    // R9
    a_r9_reset_state: assert property (@(posedge clk_i)
        rst_i |=> (!qry_active_o && qry_bank_o == '0 && !rvalid_o));

endmodule

// File: tb/flashq_cmd_top_tb_top.sv
module flashq_cmd_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr;
    logic        rd;
    logic [19:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        rvalid;
    logic        arr_rd;
    logic [19:0] arr_addr;
    logic [15:0] arr_rdata;
    logic        q_act;
    logic [3:0]  q_bank;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    localparam logic [15:0] ID_TAB [23] = '{
        16'h0051, 16'h0052, 16'h0059, 16'h0002, 16'h0000, 16'h0040, 16'h0000,
        16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0017, 16'h0019, 16'h0000,
        16'h0000, 16'h0006, 16'h0009, 16'h000A, 16'h0000, 16'h0004, 16'h0004,
        16'h0003, 16'h0000
    };

    always #4 clk = ~clk;

    function automatic logic [15:0] arr_model(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h3C3};
    endfunction

    assign arr_rdata = arr_rd ? arr_model(arr_addr) : 16'hDEAD;

    flashq_cmd_top dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .wr_i         (wr),
        .rd_i         (rd),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .rvalid_o     (rvalid),
        .arr_rd_o     (arr_rd),
        .arr_addr_o   (arr_addr),
        .arr_rdata_i  (arr_rdata),
        .qry_active_o (q_act),
        .qry_bank_o   (q_bank)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] b, input logic [15:0] o, input logic [15:0] d);
        @(negedge clk);
        rd = 1'b0; wr = 1'b1; addr = {b, o}; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] b, input logic [15:0] o,
                           input logic [15:0] e, input bit to_array, input string tag);
        exp_t it;
        @(negedge clk);
        wr = 1'b0; rd = 1'b1; addr = {b, o};
        it.val = e; it.tag = tag;
        sb.push_back(it);
        #1;
        if (to_array) check(arr_rd === 1'b1 && arr_addr === {b, o}, "R5 arr_rd", {arr_rd, arr_addr}, {1'b1, b, o});
        else          check(arr_rd === 1'b0, "R5 no arr_rd", arr_rd, 0);
    endtask

    task automatic idle();
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    task automatic check_mode(input bit a, input logic [3:0] b, input string tag);
        check(q_act === a && q_bank === b, tag, {q_act, q_bank}, {a, b});
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (!rst && rvalid === 1'b1) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected rvalid", rvalid, 0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                check(rdata === it.val, it.tag, rdata, it.val);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        check_mode(1'b0, 4'd0, "R9 reset mode");
        check(rvalid === 1'b0 && rdata === 16'h0, "R9 reset read regs", {rvalid, rdata}, 0);
        rst = 1'b0;

        // array mode read
        do_read(4'd3, 16'h0010, arr_model({4'd3, 16'h0010}), 1'b1, "R5 array read array-mode");
        idle();

        // R11 wrong offset, then upper offset bits ignored
        do_write(4'd2, 16'h0554, 16'h0098);
        check_mode(1'b0, 4'd0, "R11 wrong offset no entry");
        do_write(4'd2, 16'h0556, 16'h0098);
        check_mode(1'b0, 4'd0, "R11 wrong offset no entry 2");
        do_write(4'd2, 16'h1555, 16'h0098);
        check_mode(1'b1, 4'd2, "R1 R11 entry with upper bits set");

        // table, back-to-back (R10)
        for (int i = 0; i < 23; i++)
            do_read(4'd2, 16'(16 + i), ID_TAB[i], 1'b0, (i < 3) ? "R2 id string" : "R3 id table");
        idle();
        for (int o = 0; o < 16; o++)
            do_read(4'd2, 16'(o), 16'h0000, 1'b0, "R4 below table");
        for (int o = 16'h27; o < 16'h80; o++)
            do_read(4'd2, 16'(o), 16'h0000, 1'b0, "R4 above table");
        do_read(4'd2, 16'h0555, 16'h0000, 1'b0, "R4 far offset");
        idle();

        // other banks readable
        do_read(4'd5, 16'h0010, arr_model({4'd5, 16'h0010}), 1'b1, "R5 other bank in query");
        do_read(4'd0, 16'h0011, arr_model({4'd0, 16'h0011}), 1'b1, "R5 other bank in query 2");
        idle();

        // R6 foreign writes refused
        do_write(4'd7, 16'h0000, 16'h00F0);
        check_mode(1'b1, 4'd2, "R6 foreign exit refused");
        do_write(4'd7, 16'h0555, 16'h0098);
        check_mode(1'b1, 4'd2, "R6 foreign entry refused");

        // R8 other writes to query bank ignored
        do_write(4'd2, 16'h0555, 16'h0098);
        check_mode(1'b1, 4'd2, "R8 re-entry ignored");
        do_write(4'd2, 16'h0000, 16'h00FF);
        check_mode(1'b1, 4'd2, "R8 other data ignored");
        do_read(4'd2, 16'h0012, 16'h0059, 1'b0, "R8 still in query");
        idle();

        // R7 exit
        do_write(4'd2, 16'h0000, 16'h00F0);
        check_mode(1'b0, 4'd0, "R7 exit");
        do_read(4'd2, 16'h0010, arr_model({4'd2, 16'h0010}), 1'b1, "R7 array after exit");
        idle();

        // re-enter on bank 15
        do_write(4'd15, 16'h0555, 16'h0098);
        check_mode(1'b1, 4'd15, "R1 entry bank 15");
        do_read(4'd15, 16'h0011, 16'h0052, 1'b0, "R2 bank 15 id");
        do_read(4'd2, 16'h0011, arr_model({4'd2, 16'h0011}), 1'b1, "R5 old bank array");
        idle();
        do_write(4'd15, 16'h0000, 16'hAAF0);
        check_mode(1'b0, 4'd0, "R7 exit low byte");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10 all reads answered", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule